// File: doc/BRIEF.md
# PLL Multiplier and Divider Search Engine

This block works out the feedback multiplier M and the input divider N for a lane PLL. It takes a reference frequency and a per-lane high-speed data rate. The output target is half the lane rate. The engine picks a post-divider from that target. It then steps through every permitted N in ascending order. For each N it computes a rounded M, discards any candidate whose M or resulting output frequency falls outside the legal window, and keeps the candidate with the smallest frequency error. All frequencies are integers: the reference and the output are in kHz, and the lane rate is in kbit/s.

A request is made with a one-cycle `start` pulse. The block raises `busy` while the search runs. It finishes with a one-cycle `done` pulse. At that point `err`, `m_out`, `n_out` and `fout_khz` carry the result, and they hold it until the next completion. Every division uses one shared multi-cycle restoring divider, so a search costs tens to hundreds of cycles per N.

Top module: `pll_mn_search`

## Requirements
- R1: A lane rate below 80000 kbit/s or above 2500000 kbit/s ends the search with `err` = 1. Both 80000 and 2500000 are accepted.
- R2: A reference below 2000 kHz or above 64000 kHz ends the search with `err` = 1. Both 2000 and 64000 are accepted.
- R3: The target is Fout = floor(rate / 2) kHz. The post-divider D is 8 when Fout <= 80000, 4 when Fout <= 160000, 2 when Fout <= 320000, and 1 above that.
- R4: The engine tries N from max(1, ceil(Fin / 8000)) up to min(16, max(1, floor(Fin / 2000))) in ascending order. A successful result always has 1 <= `n_out` <= 16.
- R5: For each N, M = floor((Fout·N·D + floor(Fin/2)) / Fin). A candidate with M below 64 or above 625 is dropped.
- R6: The achieved frequency is floor(M·Fin / (N·D)). A candidate with this value below 40000 kHz or above 1250000 kHz is dropped. `fout_khz` reports the achieved frequency of the winner.
- R7: A later candidate replaces the kept one only when its absolute error |achieved − Fout| is strictly smaller. On a tie, the smaller N wins.
- R8: When no candidate survives, or when the inputs are invalid, the block reports `err` = 1 with `m_out`, `n_out` and `fout_khz` all zero.
- R9: `done` is a single-cycle pulse. `busy` is high from the cycle after an accepted `start` until the cycle in which `done` rises. A `start` while `busy` is high is ignored. The outputs hold their values between completions.
- R10: A `start` presented in the cycle where `done` is high is accepted as a new request.
- R11: During and directly after reset, `busy`, `done`, `err`, `m_out`, `n_out` and `fout_khz` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request pulse, sampled when idle |
| ref_khz | input | FIN_W (17) | Reference frequency in kHz |
| lane_kbps | input | RATE_W (22) | Lane data rate in kbit/s |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | No valid configuration, or invalid inputs |
| m_out | output | M_W (10) | Selected feedback multiplier |
| n_out | output | N_W (5) | Selected input divider |
| fout_khz | output | RATE_W-1 (21) | Achieved output frequency in kHz |

## Verification
Two events can fall in the same cycle: the completion of one search, signalled by `done`, and the acceptance of the next `start`. The bench provokes this by driving a new request on the exact cycle it observes `done`. It then judges three things. The first result must match its own model values. `busy` must rise one cycle later. The second completion must carry the model result for the second request. A separate case pulses `start` with different operands in the middle of a search. That case must leave the first result unchanged, and no extra completion may appear afterwards.

// File: rtl/pllsrch_pkg.sv
package pllsrch_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_CHECK,
      S_LAUNCH_M,
      S_WAIT_M,
      S_LAUNCH_F,
      S_WAIT_F,
      S_NEXT,
      S_DONE
   } srch_state_t;

   localparam int unsigned DEF_RATE_MIN = 80000;
   localparam int unsigned DEF_RATE_MAX = 2500000;
   localparam int unsigned DEF_FIN_MIN  = 2000;
   localparam int unsigned DEF_FIN_MAX  = 64000;
   localparam int unsigned DEF_PFD_MIN  = 2000;
   localparam int unsigned DEF_PFD_MAX  = 8000;
   localparam int unsigned DEF_BAND     = 80000;
   localparam int unsigned DEF_M_MIN    = 64;
   localparam int unsigned DEF_M_MAX    = 625;
   localparam int unsigned DEF_FOUT_MIN = 40000;
   localparam int unsigned DEF_FOUT_MAX = 1250000;

endpackage

// File: rtl/pllsrch_bounds.sv
module pllsrch_bounds #(
   parameter int unsigned FIN_W   = 17,
   parameter int unsigned FOUT_W  = 21,
   parameter int unsigned N_W     = 5,
   parameter int unsigned N_LIMIT = 16,
   parameter int unsigned PFD_MIN = 2000,
   parameter int unsigned PFD_MAX = 8000,
   parameter int unsigned BAND    = 80000,
   parameter int unsigned FIN_MIN = 2000,
   parameter int unsigned FIN_MAX = 64000
) (
   input  logic [FIN_W-1:0]  fin,
   input  logic [FOUT_W-1:0] fout,
   output logic [N_W-1:0]    nmin,
   output logic [N_W-1:0]    nmax,
   output logic [1:0]        div_sh,
   output logic              fin_ok
);

   logic [N_LIMIT-1:0] lo_hit;
   logic [N_LIMIT-1:0] hi_hit;
   logic [N_W-1:0]     lo_cnt;
   logic [N_W-1:0]     hi_cnt;

   // one comparator per candidate divider: counting the hits yields ceil/floor quotients
   for (genvar i = 0; i < N_LIMIT; i++) begin : g_step
      localparam logic [31:0] LO_STEP = 32'(i * PFD_MAX);
      localparam logic [31:0] HI_STEP = 32'((i + 1) * PFD_MIN);
      assign lo_hit[i] = 32'(fin) >  LO_STEP;
      assign hi_hit[i] = 32'(fin) >= HI_STEP;
   end

   always_comb begin
      lo_cnt = '0;
      hi_cnt = '0;
      for (int i = 0; i < N_LIMIT; i++) begin
         lo_cnt = lo_cnt + {{(N_W-1){1'b0}}, lo_hit[i]};
         hi_cnt = hi_cnt + {{(N_W-1){1'b0}}, hi_hit[i]};
      end
   end

   assign nmin   = (lo_cnt == '0) ? N_W'(1) : lo_cnt;
   assign nmax   = (hi_cnt == '0) ? N_W'(1) : hi_cnt;
   assign fin_ok = (32'(fin) >= 32'(FIN_MIN)) && (32'(fin) <= 32'(FIN_MAX));

   always_comb begin
      if (32'(fout) <= 32'(BAND))          div_sh = 2'd3;
      else if (32'(fout) <= 32'(2 * BAND)) div_sh = 2'd2;
      else if (32'(fout) <= 32'(4 * BAND)) div_sh = 2'd1;
      else                                 div_sh = 2'd0;
   end

   always_comb begin
      if (fin_ok) begin
         p_nbounds_r4: assert (nmin >= N_W'(1) && nmin <= nmax && 32'(nmax) <= N_LIMIT)
            else $error("divider bounds out of order");
      end
   end

endmodule

// File: rtl/pllsrch_divider.sv
module pllsrch_divider #(
   parameter int unsigned W = 28
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go,
   input  logic [W-1:0] dividend,
   input  logic [W-1:0] divisor,
   output logic         fin,
   output logic [W-1:0] quotient
);

   localparam int unsigned CNT_W = $clog2(W + 1);

   logic [W-1:0]     q_r;
   logic [W-1:0]     d_r;
   logic [W:0]       rem_r;
   logic [CNT_W-1:0] cnt;
   logic             run;
   logic [W:0]       rem_sh;
   logic [W+1:0]     diff;
   logic             neg;

   assign rem_sh   = {rem_r[W-1:0], q_r[W-1]};
   assign diff     = {1'b0, rem_sh} - {2'b00, d_r};
   assign neg      = diff[W+1];
   assign quotient = q_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_r   <= '0;
         d_r   <= '0;
         rem_r <= '0;
         cnt   <= '0;
         run   <= 1'b0;
         fin   <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (go) begin
            q_r   <= dividend;
            d_r   <= divisor;
            rem_r <= '0;
            cnt   <= CNT_W'(W);
            run   <= 1'b1;
         end else if (run) begin
            rem_r <= neg ? rem_sh : diff[W:0];
            q_r   <= {q_r[W-2:0], ~neg};
            cnt   <= cnt - CNT_W'(1);
            if (cnt == CNT_W'(1)) begin
               run <= 1'b0;
               fin <= 1'b1;
            end
         end
      end
   end

   // a finished division leaves a remainder below the divisor (feeds R5/R6)
   p_rem_lt_div_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fin |-> (rem_r < {1'b0, d_r}));

   p_go_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> !run);

endmodule

// File: rtl/pllsrch_score.sv
module pllsrch_score #(
   parameter int unsigned DIV_W    = 28,
   parameter int unsigned FOUT_W   = 21,
   parameter int unsigned FOUT_MIN = 40000,
   parameter int unsigned FOUT_MAX = 1250000
) (
   input  logic [DIV_W-1:0]  achieved,
   input  logic [FOUT_W-1:0] target,
   input  logic [FOUT_W-1:0] best_d,
   input  logic              found,
   output logic              in_range,
   output logic [FOUT_W-1:0] delta,
   output logic              take
);

   logic [FOUT_W-1:0] a_cut;

   assign in_range = (achieved >= DIV_W'(FOUT_MIN)) && (achieved <= DIV_W'(FOUT_MAX));
   assign a_cut    = achieved[FOUT_W-1:0];
   assign delta    = (a_cut >= target) ? (a_cut - target) : (target - a_cut);
   assign take     = in_range && (!found || (delta < best_d));

endmodule

// File: rtl/pll_mn_search.sv
module pll_mn_search
   import pllsrch_pkg::*;
#(
   parameter int unsigned FIN_W    = 17,
   parameter int unsigned RATE_W   = 22,
   parameter int unsigned DIV_W    = 28,
   parameter int unsigned M_W      = 10,
   parameter int unsigned N_W      = 5,
   parameter int unsigned N_LIMIT  = 16,
   parameter int unsigned RATE_MIN = DEF_RATE_MIN,
   parameter int unsigned RATE_MAX = DEF_RATE_MAX,
   parameter int unsigned FIN_MIN  = DEF_FIN_MIN,
   parameter int unsigned FIN_MAX  = DEF_FIN_MAX,
   parameter int unsigned M_MIN    = DEF_M_MIN,
   parameter int unsigned M_MAX    = DEF_M_MAX,
   parameter int unsigned FOUT_MIN = DEF_FOUT_MIN,
   parameter int unsigned FOUT_MAX = DEF_FOUT_MAX
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [FIN_W-1:0]  ref_khz,
   input  logic [RATE_W-1:0] lane_kbps,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic [M_W-1:0]    m_out,
   output logic [N_W-1:0]    n_out,
   output logic [RATE_W-2:0] fout_khz
);

   localparam int unsigned FOUT_W = RATE_W - 1;
   localparam int unsigned ND_W   = N_W + 3;

   if (DIV_W < FOUT_W + ND_W - 1) begin : g_bad_div_w
      $error("DIV_W too narrow for the multiplier numerator");
   end
   if (DIV_W < M_W + FIN_W) begin : g_bad_prod_w
      $error("DIV_W too narrow for M times reference");
   end
   if (N_LIMIT >= (1 << N_W)) begin : g_bad_n_w
      $error("N_W cannot hold N_LIMIT");
   end
   if (M_MAX >= (1 << M_W)) begin : g_bad_m_w
      $error("M_W cannot hold M_MAX");
   end

   srch_state_t       state;
   logic [FIN_W-1:0]  fin_q;
   logic [RATE_W-1:0] rate_q;
   logic [N_W-1:0]    n_r;
   logic [M_W-1:0]    m_r;
   logic [M_W-1:0]    best_m;
   logic [N_W-1:0]    best_n;
   logic [FOUT_W-1:0] best_f;
   logic [FOUT_W-1:0] best_d;
   logic              found;

   logic [FOUT_W-1:0] fout_t;
   logic [N_W-1:0]    nmin;
   logic [N_W-1:0]    nmax;
   logic [1:0]        div_sh;
   logic              fin_ok;
   logic              rate_ok;
   logic [ND_W-1:0]   n_scaled;

   logic              dv_go;
   logic              dv_fin;
   logic [DIV_W-1:0]  dv_num;
   logic [DIV_W-1:0]  dv_den;
   logic [DIV_W-1:0]  dv_q;
   logic              m_ok;

   logic              sc_in_range;
   logic [FOUT_W-1:0] sc_delta;
   logic              sc_take;

   assign fout_t   = rate_q[RATE_W-1:1];
   assign rate_ok  = (rate_q >= RATE_W'(RATE_MIN)) && (rate_q <= RATE_W'(RATE_MAX));
   assign n_scaled = {3'b000, n_r} << div_sh;
   assign busy     = (state != S_IDLE);

   pllsrch_bounds #(
      .FIN_W   (FIN_W),
      .FOUT_W  (FOUT_W),
      .N_W     (N_W),
      .N_LIMIT (N_LIMIT),
      .PFD_MIN (DEF_PFD_MIN),
      .PFD_MAX (DEF_PFD_MAX),
      .BAND    (DEF_BAND),
      .FIN_MIN (FIN_MIN),
      .FIN_MAX (FIN_MAX)
   ) u_bounds (
      .fin    (fin_q),
      .fout   (fout_t),
      .nmin   (nmin),
      .nmax   (nmax),
      .div_sh (div_sh),
      .fin_ok (fin_ok)
   );

   // one divider serves both quotients; the launching state selects the operands
   assign dv_go  = (state == S_LAUNCH_M) || (state == S_LAUNCH_F);
   assign dv_num = (state == S_LAUNCH_M)
                 ? (DIV_W'(fout_t) * DIV_W'(n_scaled) + DIV_W'(fin_q >> 1))
                 : (DIV_W'(m_r) * DIV_W'(fin_q));
   assign dv_den = (state == S_LAUNCH_M) ? DIV_W'(fin_q) : DIV_W'(n_scaled);

   pllsrch_divider #(
      .W (DIV_W)
   ) u_divider (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (dv_go),
      .dividend (dv_num),
      .divisor  (dv_den),
      .fin      (dv_fin),
      .quotient (dv_q)
   );

   assign m_ok = (dv_q >= DIV_W'(M_MIN)) && (dv_q <= DIV_W'(M_MAX));

   pllsrch_score #(
      .DIV_W    (DIV_W),
      .FOUT_W   (FOUT_W),
      .FOUT_MIN (FOUT_MIN),
      .FOUT_MAX (FOUT_MAX)
   ) u_score (
      .achieved (dv_q),
      .target   (fout_t),
      .best_d   (best_d),
      .found    (found),
      .in_range (sc_in_range),
      .delta    (sc_delta),
      .take     (sc_take)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= S_IDLE;
         fin_q    <= '0;
         rate_q   <= '0;
         n_r      <= '0;
         m_r      <= '0;
         best_m   <= '0;
         best_n   <= '0;
         best_f   <= '0;
         best_d   <= '1;
         found    <= 1'b0;
         done     <= 1'b0;
         err      <= 1'b0;
         m_out    <= '0;
         n_out    <= '0;
         fout_khz <= '0;
      end else begin
         done <= 1'b0;
         unique case (state)
            S_IDLE: begin
               if (start) begin
                  fin_q  <= ref_khz;
                  rate_q <= lane_kbps;
                  state  <= S_CHECK;
               end
            end
            S_CHECK: begin
               found  <= 1'b0;
               best_d <= '1;
               if (!fin_ok || !rate_ok || (nmin > nmax)) begin
                  state <= S_DONE;
               end else begin
                  n_r   <= nmin;
                  state <= S_LAUNCH_M;
               end
            end
            S_LAUNCH_M: state <= S_WAIT_M;
            S_WAIT_M: begin
               if (dv_fin) begin
                  m_r   <= dv_q[M_W-1:0];
                  state <= m_ok ? S_LAUNCH_F : S_NEXT;
               end
            end
            S_LAUNCH_F: state <= S_WAIT_F;
            S_WAIT_F: begin
               if (dv_fin) begin
                  if (sc_take) begin
                     best_m <= m_r;
                     best_n <= n_r;
                     best_f <= dv_q[FOUT_W-1:0];
                     best_d <= sc_delta;
                     found  <= 1'b1;
                  end
                  state <= S_NEXT;
               end
            end
            S_NEXT: begin
               if (n_r >= nmax) begin
                  state <= S_DONE;
               end else begin
                  n_r   <= n_r + N_W'(1);
                  state <= S_LAUNCH_M;
               end
            end
            S_DONE: begin
               done     <= 1'b1;
               err      <= !found;
               m_out    <= found ? best_m : '0;
               n_out    <= found ? best_n : '0;
               fout_khz <= found ? best_f : '0;
               state    <= S_IDLE;
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_err_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && err) |-> (m_out == '0 && n_out == '0 && fout_khz == '0));

   p_m_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !err) |-> (32'(m_out) >= M_MIN && 32'(m_out) <= M_MAX));

   p_n_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !err) |-> (n_out >= N_W'(1) && 32'(n_out) <= N_LIMIT));

   p_fout_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !err) |-> (32'(fout_khz) >= FOUT_MIN && 32'(fout_khz) <= FOUT_MAX));

   p_rate_reject_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (32'(rate_q) < RATE_MIN || 32'(rate_q) > RATE_MAX)) |-> err);

   p_ref_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (32'(fin_q) < FIN_MIN || 32'(fin_q) > FIN_MAX)) |-> err);

   p_hold_operands_r9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(fin_q) && $stable(rate_q)));

   p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> busy);

   p_out_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state != S_DONE) |=> ($stable(m_out) && $stable(n_out) && $stable(fout_khz)));

endmodule

// File: tb/pll_mn_search_bench.sv
module pll_mn_search_bench;

   localparam int FIN_W  = 17;
   localparam int RATE_W = 22;
   localparam int M_W    = 10;
   localparam int N_W    = 5;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [FIN_W-1:0]  ref_khz = '0;
   logic [RATE_W-1:0] lane_kbps = '0;
   logic              busy;
   logic              done;
   logic              err;
   logic [M_W-1:0]    m_out;
   logic [N_W-1:0]    n_out;
   logic [RATE_W-2:0] fout_khz;

   int checks = 0;
   int fails  = 0;
   bit closed = 1'b0;

   bit     q_e[$];
   longint q_m[$];
   longint q_n[$];
   longint q_f[$];
   string  q_tag[$];

   always #10 clk = ~clk;

   pll_mn_search u_pll_mn_search (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .ref_khz   (ref_khz),
      .lane_kbps (lane_kbps),
      .busy      (busy),
      .done      (done),
      .err       (err),
      .m_out     (m_out),
      .n_out     (n_out),
      .fout_khz  (fout_khz)
   );

   task automatic check_eq(input string req, input string what, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // reference search written from the requirement text
   function automatic void model(input longint fin, input longint rate,
                                 output bit e, output longint m, output longint n, output longint f);
      longint fo, k, dv, lo, hi, mm, t, d, best;
      e = 1'b1; m = 0; n = 0; f = 0; best = 64'h7fff_ffff_ffff;
      if (rate < 80000 || rate > 2500000 || fin < 2000 || fin > 64000) return;
      fo = rate / 2;
      k  = (fo + 79999) / 80000;
      if (k > 8) k = 8;
      dv = 8 / k;
      lo = (fin + 7999) / 8000;
      hi = fin / 2000;
      if (lo < 1) lo = 1;
      if (lo > 16) lo = 16;
      if (hi < 1) hi = 1;
      if (hi > 16) hi = 16;
      for (longint nn = lo; nn <= hi; nn++) begin
         mm = (fo * nn * dv + fin / 2) / fin;
         if (mm < 64 || mm > 625) continue;
         t = (mm * fin) / (nn * dv);
         if (t < 40000 || t > 1250000) continue;
         d = (t > fo) ? (t - fo) : (fo - t);
         if (d < best) begin
            best = d; m = mm; n = nn; f = t; e = 1'b0;
         end
      end
   endfunction

   task automatic push_exp(input longint fin, input longint rate, input string tag);
      bit e; longint m, n, f;
      model(fin, rate, e, m, n, f);
      q_e.push_back(e); q_m.push_back(m); q_n.push_back(n); q_f.push_back(f); q_tag.push_back(tag);
   endtask

   task automatic drive_start(input longint fin, input longint rate, input string tag);
      ref_khz   = FIN_W'(fin);
      lane_kbps = RATE_W'(rate);
      start     = 1'b1;
      push_exp(fin, rate, tag);
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic issue(input longint fin, input longint rate, input string tag);
      @(negedge clk);
      drive_start(fin, rate, tag);
   endtask

   task automatic wait_done();
      do @(negedge clk); while (!done);
   endtask

   task automatic run(input longint fin, input longint rate, input string tag);
      issue(fin, rate, tag);
      wait_done();
   endtask

   task automatic finish_up();
      if (!closed) begin
         closed = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (q_e.size() == 0) begin
            check_eq("R9", "unrequested done", 1, 0);
         end else begin
            bit e; longint m, n, f; string t;
            e = q_e.pop_front(); m = q_m.pop_front(); n = q_n.pop_front();
            f = q_f.pop_front(); t = q_tag.pop_front();
            check_eq(t, "err", longint'(err), longint'(e));
            check_eq(t, "m_out", longint'(m_out), m);
            check_eq(t, "n_out", longint'(n_out), n);
            check_eq(t, "fout_khz", longint'(fout_khz), f);
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
   end

   initial begin
      bit ae; longint am, an, af;
      int extra;
      repeat (3) @(negedge clk);
      // R11: values held in reset
      check_eq("R11", "busy", busy, 0);
      check_eq("R11", "done", done, 0);
      check_eq("R11", "err", err, 0);
      check_eq("R11", "m_out", m_out, 0);
      check_eq("R11", "n_out", n_out, 0);
      check_eq("R11", "fout_khz", fout_khz, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check_eq("R11", "busy after release", busy, 0);
      check_eq("R11", "done after release", done, 0);

      // R3/R4/R5/R6: assorted operand patterns over all post-divider bands
      run(24000, 1000000, "R3");
      run(12000, 150000, "R3");
      run(10000, 300000, "R3");
      run(33000, 500000, "R4");
      run(19200, 891000, "R5");
      run(27000, 445500, "R5");
      run(50000, 1800000, "R6");
      run(24000, 1000001, "R3");

      // R3: lowest band, single divider
      run(2000, 80000, "R3");
      check_eq("R3", "m held", m_out, 160);
      check_eq("R3", "n held", n_out, 1);
      check_eq("R6", "fout held", fout_khz, 40000);

      // R7: N=4 and N=8 both hit exactly, the smaller must win
      run(16000, 1000000, "R7");
      check_eq("R7", "tie m", m_out, 125);
      check_eq("R7", "tie n", n_out, 4);
      check_eq("R7", "tie fout", fout_khz, 500000);

      // R1: lane rate limits
      run(24000, 79999, "R1");
      check_eq("R1", "err low rate", err, 1);
      run(24000, 80000, "R1");
      run(24000, 2500000, "R1");
      run(24000, 2500001, "R1");
      check_eq("R1", "err high rate", err, 1);

      // R2: reference limits
      run(1999, 1000000, "R2");
      check_eq("R2", "err low ref", err, 1);
      run(64001, 1000000, "R2");
      check_eq("R2", "err high ref", err, 1);
      run(2000, 200000, "R2");
      check_eq("R2", "m at low ref", m_out, 200);
      run(64000, 2000000, "R2");

      // R8: only candidate lands at 39990 kHz, below the floor
      run(3999, 80000, "R8");
      check_eq("R8", "err no candidate", err, 1);
      check_eq("R8", "m zero", m_out, 0);

      // R9: start during a search is ignored
      model(24000, 1000000, ae, am, an, af);
      issue(24000, 1000000, "R9");
      check_eq("R9", "busy after start", busy, 1);
      repeat (3) @(negedge clk);
      ref_khz = 17'd10000; lane_kbps = 22'd300000; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check_eq("R9", "busy mid search", busy, 1);
      wait_done();
      @(negedge clk);
      check_eq("R9", "done one cycle", done, 0);
      extra = 0;
      for (int i = 0; i < 120; i++) begin
         @(negedge clk);
         if (done) extra++;
      end
      check_eq("R9", "extra completions", extra, 0);
      check_eq("R9", "m still held", m_out, am);
      check_eq("R9", "n still held", n_out, an);
      check_eq("R9", "busy idle", busy, 0);

      // R10: new start on the completion cycle
      issue(33000, 500000, "R10");
      wait_done();
      drive_start(12000, 150000, "R10");
      check_eq("R10", "busy after same-cycle start", busy, 1);
      wait_done();

      repeat (5) @(negedge clk);
      check_eq("R9", "scoreboard drained", q_e.size(), 0);
      finish_up();
   end

endmodule